// File: doc/BRIEF.md
# Burst-of-two quad-rate SRAM model

This block is a synthesizable, cycle-accurate model of a quad-rate synchronous SRAM. It has one data-in port and one data-out port, and every access moves a pair of words. A single fast clock stands in for both rising edges of the slower memory clock. The input `ph` tells the two apart: `ph` = 0 marks the main (K) edge and `ph` = 1 marks the complementary edge half a period later. A read and a write share one address bus but use it on opposite edges, so both can be issued in the same slow cycle.

Write data is taken one word per edge. The write address arrives on the edge after the command. The completed write waits in a pending register for one more edge before it reaches the array. A read that hits that pending pair takes the pending bytes for every lane whose enable was set. This keeps read results coherent with the newest write while the write path stays short. The array is small and parameterized. Read data is registered, and the output is driven to zero whenever no read word is presented.

Top module: `qdr_burst2_sram`

## Requirements
- R1: A read is accepted when `rd_sel` is high at a `ph`=0 edge, with its pair address on `addr` at that edge. Its first word is presented after the second edge that follows, which is the next `ph`=0 edge.
- R2: A write is accepted when `wr_sel` is high at a `ph`=0 edge. `din` and `bwe` at that edge form word 0. At the following `ph`=1 edge, `addr` gives the pair address and `din` and `bwe` form word 1.
- R3: Each pair address `a` names two array words: `2a` is carried first and `2a+1` second, for both reads and writes.
- R4: A read presents word 0 and then word 1 on two consecutive edges. `dout_vld` is high for exactly those two edges and rises after a `ph`=0 edge.
- R5: Read commands on consecutive `ph`=0 edges give an unbroken output stream, with `dout_vld` staying high across the bursts.
- R6: Once the last burst has finished, `dout_vld` falls at the next `ph`=0 edge. Whenever `dout_vld` is low, `dout` is all zeros.
- R7: Byte lane `i` covers bits `i*DW/NB` up to `(i+1)*DW/NB-1`; with the defaults, lane 0 is bits 0..8 and lane 1 is bits 17..9. A word lane is written only when its `bwe` bit is 1 for that word. Other lanes keep their old contents.
- R8: A read and a write to the same pair address, issued on the same `ph`=0 edge, return the new write data in the enabled lanes and the older contents in the other lanes.
- R9: A read returns every write whose command edge was at or before the read's command edge.
- R10: After reset, `dout_vld` is low, `dout` is zero and every array word reads as zero.
- R11: `rd_sel` and `wr_sel` are ignored at `ph`=1 edges. They start no output and change no array word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two edges per memory cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ph | input | 1 | Edge phase: 0 main edge, 1 complementary edge |
| rd_sel | input | 1 | Read command, active high |
| wr_sel | input | 1 | Write command, active high |
| addr | input | AW | Shared pair address |
| bwe | input | NB | Per-lane write enables, active high |
| din | input | DW | Write data word |
| dout | output | DW | Read data word, zero when idle |
| dout_vld | output | 1 | High while `dout` carries a read word |

## Verification
The assertions assume that `ph` alternates on every clock after reset, which the bench guarantees by driving it from a two-edge task. They do not assume that commands occur only on `ph`=0 edges: the bench deliberately raises both selects on `ph`=1 edges to show they are dropped. Reads are not reset mid-burst, so the fixed three-edge latency property always sees a complete burst.

// File: rtl/qb2_pkg.sv
// Shared types for the burst-of-two quad-rate SRAM model.
package qb2_pkg;
    // What the data-out register currently holds.
    typedef enum logic [1:0] {
        OUT_IDLE   = 2'd0,
        OUT_FIRST  = 2'd1,
        OUT_SECOND = 2'd2
    } out_stage_e;
endpackage

// File: rtl/qb2_write_path.sv
// Write capture: word 0 and its enables are taken on the main edge together
// with the command; address, word 1 and its enables on the next edge. The
// complete pair then sits in a pending register for one edge.
// Assumes ph alternates every clock.
module qb2_write_path #(
    parameter int DW = 18,
    parameter int NB = 2,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          wr_sel,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] bwe,
    input  logic [DW-1:0] din,
    output logic          pend_vld,
    output logic [AW-1:0] pend_base,
    output logic [DW-1:0] pend_d0,
    output logic [DW-1:0] pend_d1,
    output logic [NB-1:0] pend_m0,
    output logic [NB-1:0] pend_m1
);
    logic          cap_vld;
    logic [DW-1:0] cap_d0;
    logic [NB-1:0] cap_m0;

    // First half of a write on the main edge, completion on the other edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld   <= 1'b0;
            cap_d0    <= '0;
            cap_m0    <= '0;
            pend_vld  <= 1'b0;
            pend_base <= '0;
            pend_d0   <= '0;
            pend_d1   <= '0;
            pend_m0   <= '0;
            pend_m1   <= '0;
        end else if (!ph) begin
            cap_vld  <= wr_sel;
            pend_vld <= 1'b0;
            if (wr_sel) begin
                cap_d0 <= din;
                cap_m0 <= bwe;
            end
        end else begin
            cap_vld  <= 1'b0;
            pend_vld <= cap_vld;
            if (cap_vld) begin
                pend_base <= addr;
                pend_d0   <= cap_d0;
                pend_m0   <= cap_m0;
                pend_d1   <= din;
                pend_m1   <= bwe;
            end
        end
    end
endmodule

// File: rtl/qb2_store.sv
// Word array with lane-masked commit of the pending pair on the main edge,
// and a combinational read port that forwards pending lanes on a hit.
// Assumes pend_vld is only high in the cycle before a main edge.
module qb2_store #(
    parameter int DW = 18,
    parameter int NB = 2,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          pend_vld,
    input  logic [AW-1:0] pend_base,
    input  logic [DW-1:0] pend_d0,
    input  logic [DW-1:0] pend_d1,
    input  logic [NB-1:0] pend_m0,
    input  logic [NB-1:0] pend_m1,
    input  logic [AW:0]   rd_waddr,
    output logic [DW-1:0] rd_word
);
    localparam int LW    = DW / NB;
    localparam int DEPTH = 1 << (AW + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] arr_word;
    logic          hit;
    logic [NB-1:0] fwd_m;
    logic [DW-1:0] fwd_d;

    // Clear on reset, commit both words of the pending pair lane by lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (pend_vld && !ph) begin
            for (int l = 0; l < NB; l++) begin
                if (pend_m0[l]) mem[{pend_base, 1'b0}][l*LW +: LW] <= pend_d0[l*LW +: LW];
                if (pend_m1[l]) mem[{pend_base, 1'b1}][l*LW +: LW] <= pend_d1[l*LW +: LW];
            end
        end
    end

    // Select array word and the pending word that may override it.
    always_comb begin
        arr_word = mem[rd_waddr];
        hit      = pend_vld && (pend_base == rd_waddr[AW:1]);
        fwd_m    = rd_waddr[0] ? pend_m1 : pend_m0;
        fwd_d    = rd_waddr[0] ? pend_d1 : pend_d0;
    end

    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign rd_word[l*LW +: LW] = (hit && fwd_m[l]) ? fwd_d[l*LW +: LW]
                                                       : arr_word[l*LW +: LW];
    end
endmodule

// File: rtl/qb2_read_path.sv
// Read sequencing: the command is held for one memory cycle, then word 0 is
// registered on the next main edge and word 1 on the edge after it. The
// output is forced to zero when no word is presented.
// Assumes ph alternates every clock.
module qb2_read_path
    import qb2_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          rd_sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] rd_word,
    output logic [AW:0]   rd_waddr,
    output logic [DW-1:0] dout,
    output logic          dout_vld
);
    logic          req_vld;
    logic [AW-1:0] req_base;
    logic [AW-1:0] cur_base;
    out_stage_e    stage;

    // Word 0 of a queued request on main edges, word 1 on the other edges.
    assign rd_waddr = ph ? {cur_base, 1'b1} : {req_base, 1'b0};

    // Command capture and output register sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vld  <= 1'b0;
            req_base <= '0;
            cur_base <= '0;
            stage    <= OUT_IDLE;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else if (!ph) begin
            req_vld <= rd_sel;
            if (rd_sel) req_base <= addr;
            if (req_vld) begin
                cur_base <= req_base;
                dout     <= rd_word;
                dout_vld <= 1'b1;
                stage    <= OUT_FIRST;
            end else begin
                dout     <= '0;
                dout_vld <= 1'b0;
                stage    <= OUT_IDLE;
            end
        end else begin
            if (stage == OUT_FIRST) begin
                dout     <= rd_word;
                dout_vld <= 1'b1;
                stage    <= OUT_SECOND;
            end else begin
                dout     <= '0;
                dout_vld <= 1'b0;
                stage    <= OUT_IDLE;
            end
        end
    end
endmodule

// File: rtl/qdr_burst2_sram.sv
// Top of the burst-of-two quad-rate SRAM model: write capture, array with
// forwarding, and read sequencing on one fast clock with a phase input.
// Assumes DW is a multiple of NB and ph alternates every clock.
module qdr_burst2_sram #(
    parameter int DW = 18,
    parameter int NB = 2,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          rd_sel,
    input  logic          wr_sel,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] bwe,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_vld
);
    logic          pend_vld;
    logic [AW-1:0] pend_base;
    logic [DW-1:0] pend_d0;
    logic [DW-1:0] pend_d1;
    logic [NB-1:0] pend_m0;
    logic [NB-1:0] pend_m1;
    logic [AW:0]   rd_waddr;
    logic [DW-1:0] rd_word;

    qb2_write_path #(.DW(DW), .NB(NB), .AW(AW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .wr_sel    (wr_sel),
        .addr      (addr),
        .bwe       (bwe),
        .din       (din),
        .pend_vld  (pend_vld),
        .pend_base (pend_base),
        .pend_d0   (pend_d0),
        .pend_d1   (pend_d1),
        .pend_m0   (pend_m0),
        .pend_m1   (pend_m1)
    );

    qb2_store #(.DW(DW), .NB(NB), .AW(AW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .pend_vld  (pend_vld),
        .pend_base (pend_base),
        .pend_d0   (pend_d0),
        .pend_d1   (pend_d1),
        .pend_m0   (pend_m0),
        .pend_m1   (pend_m1),
        .rd_waddr  (rd_waddr),
        .rd_word   (rd_word)
    );

    qb2_read_path #(.DW(DW), .AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph),
        .rd_sel   (rd_sel),
        .addr     (addr),
        .rd_word  (rd_word),
        .rd_waddr (rd_waddr),
        .dout     (dout),
        .dout_vld (dout_vld)
    );
endmodule

// File: rtl/qb2_checker.sv
// Temporal checks on the ports of the burst-of-two SRAM model.
// Assumes the stimulus alternates ph on every clock after reset.
module qb2_checker #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ph,
    input logic          rd_sel,
    input logic [DW-1:0] dout,
    input logic          dout_vld
);
    logic started;
    logic ph_prev;

    // Track the previous phase once reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
        ph_prev <= ph;
    end

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (ph != ph_prev));                                  // R1
    AST_RD_TWO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && !ph) |-> ##3 dout_vld ##1 dout_vld);                // R4
    AST_FIRST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && ph) |=> dout_vld);                                // R4
    AST_VLD_RISES_AFTER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_vld) |-> ph);                                       // R4
    AST_VLD_FALLS_AFTER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_vld) |-> ph);                                       // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));                                   // R6
endmodule

bind qdr_burst2_sram qb2_checker #(.DW(DW)) u_qb2_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph       (ph),
    .rd_sel   (rd_sel),
    .dout     (dout),
    .dout_vld (dout_vld)
);

// File: tb/test_qdr_burst2_sram.sv
`timescale 1ns/1ps
// Bench: behavioural memory model updated per edge, compared on every clock.
module test_qdr_burst2_sram;
    localparam int DW = 18;
    localparam int NB = 2;
    localparam int AW = 5;
    localparam int LW = DW / NB;
    localparam int DEPTH = 1 << (AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ph = 1'b1;
    logic          rd_sel = 1'b0;
    logic          wr_sel = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] bwe = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_vld;

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R10";
    bit    done = 1'b0;

    qdr_burst2_sram #(.DW(DW), .NB(NB), .AW(AW)) i_qdr_burst2_sram (
        .clk(clk), .rst_n(rst_n), .ph(ph), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .addr(addr), .bwe(bwe), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    always #2.5 clk = ~clk;

    // Reference model state.
    logic [DW-1:0] mm [DEPTH];
    bit            rh_v [4];
    int            rh_a [4];
    bit            wp;
    logic [DW-1:0] wd0;
    logic [NB-1:0] wm0;
    logic [DW-1:0] exp_d;
    bit            exp_v;

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NB-1:0] m);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < NB; l++)
            if (m[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
        return r;
    endfunction

    // Model: reads resolved before the write completing on the same edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mm[w] = '0;
            for (int k = 0; k < 4; k++) begin rh_v[k] = 0; rh_a[k] = 0; end
            wp = 0; exp_v = 0; exp_d = '0;
        end else begin
            for (int k = 3; k > 0; k--) begin rh_v[k] = rh_v[k-1]; rh_a[k] = rh_a[k-1]; end
            rh_v[0] = !ph && rd_sel;
            rh_a[0] = int'(addr);
            if (rh_v[2])      begin exp_v = 1; exp_d = mm[2*rh_a[2]];     end
            else if (rh_v[3]) begin exp_v = 1; exp_d = mm[2*rh_a[3] + 1]; end
            else              begin exp_v = 0; exp_d = '0;                end
            if (!ph) begin
                wp = wr_sel;
                if (wr_sel) begin wd0 = din; wm0 = bwe; end
            end else if (wp) begin
                mm[2*int'(addr)]     = mrg(mm[2*int'(addr)], wd0, wm0);
                mm[2*int'(addr) + 1] = mrg(mm[2*int'(addr) + 1], din, bwe);
                wp = 0;
            end
        end
    end

    // Compare ports with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (dout_vld !== exp_v || dout !== exp_d) begin
                n_fail++;
                $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h",
                         tag, dout_vld, dout, exp_v, exp_d);
            end
        end
    end

    task automatic kcycle(input bit rd, input bit wr,
                          input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                          input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [NB-1:0] m0, input logic [NB-1:0] m1,
                          input bit xr = 0, input bit xw = 0);
        @(negedge clk);
        ph = 1'b0; rd_sel = rd; wr_sel = wr; addr = ra; din = d0; bwe = m0;
        @(negedge clk);
        ph = 1'b1; rd_sel = xr; wr_sel = xw; addr = wa; din = d1; bwe = m1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) kcycle(0, 0, '0, '0, '0, '0, '0, '0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R10: reset state at the ports.
        n_chk++;
        if (dout_vld !== 1'b0 || dout !== '0) begin
            n_fail++;
            $display("FAIL R10: vld=%0b dout=%h expected vld=0 dout=0", dout_vld, dout);
        end
        tag = "R10"; kcycle(1, 0, 5'd9, '0, '0, '0, '0, '0); idle(3);

        tag = "R2/R3";
        kcycle(0, 1, '0, 5'd4, 18'h12345, 18'h2abcd, 2'b11, 2'b11);
        kcycle(0, 1, '0, 5'd7, 18'h00f0f, 18'h3f0f0, 2'b11, 2'b11);
        idle(2);
        tag = "R1/R4/R6";
        kcycle(1, 0, 5'd4, '0, '0, '0, '0, '0); idle(4);
        tag = "R5";
        kcycle(1, 0, 5'd4, '0, '0, '0, '0, '0);
        kcycle(1, 0, 5'd7, '0, '0, '0, '0, '0);
        kcycle(1, 0, 5'd4, '0, '0, '0, '0, '0); idle(4);

        tag = "R7";
        kcycle(0, 1, '0, 5'd4, 18'h3ffff, 18'h3ffff, 2'b01, 2'b10); idle(1);
        kcycle(1, 0, 5'd4, '0, '0, '0, '0, '0); idle(4);

        tag = "R8";
        kcycle(1, 1, 5'd7, 5'd7, 18'h15555, 18'h0aaaa, 2'b10, 2'b01); idle(4);
        tag = "R9";
        kcycle(0, 1, '0, 5'd3, 18'h11111, 18'h22222, 2'b11, 2'b11);
        kcycle(1, 0, 5'd3, '0, '0, '0, '0, '0); idle(4);

        tag = "R11";
        kcycle(0, 0, 5'd3, 5'd3, 18'h3ffff, 18'h3ffff, 2'b11, 2'b11, 1, 1);
        idle(4);
        kcycle(1, 0, 5'd3, '0, '0, '0, '0, '0); idle(4);

        tag = "R8/R9";
        for (int i = 0; i < 400; i++)
            kcycle(1'($urandom), 1'($urandom), AW'($urandom % 4), AW'($urandom % 4),
                   DW'($urandom), DW'($urandom), NB'($urandom), NB'($urandom),
                   1'($urandom), 1'($urandom));
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL R1: watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule